// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block collects a parameterised set of interrupt sources (96 by default) into 32-bit banks and drives one interrupt line toward a processor. Software programs per-source enable and mask bits through a small register bus. It then reads a vector register that names the lowest-numbered source that is active, or it scans the pending banks. Source `n` sits in bank `n/32` at bit `n%32`. Every source except number 0 is level-following: its pending bit is the source level sampled on the previous clock, so it needs no acknowledge.

Source 0 is an external pin. The pin passes through a two-flop synchroniser, then a trigger selected by software: low level, high level, falling edge or rising edge. The trigger sets a sticky pending bit, and that bit stays set until software writes a one to clear it. The vector register encodes the winning source as a byte offset (number times four). A zero vector therefore means either "nothing active" or "source 0 active", and software tells the two apart by reading bit 0 of pending bank 0.

The register bus is a plain single-cycle port. A write takes effect at the clock edge where the write enable is high. Read data is combinational from the address. There is no handshake and no back-pressure: every access completes in its own cycle. A protection bit, once set, turns away every write that does not carry the privileged-access qualifier.

Top module: `banked_irq_ctrl`

## Requirements
- R1: For every source n ≥ 1, the pending bit at bank n/32, bit n%32, equals the source level sampled on the previous clock edge. Pending banks are at byte addresses 0x10, 0x14 and 0x18. Writing ones to these bits leaves no lasting change.
- R2: A read of address 0x00 returns the lowest-numbered active source times four, with bits [1:0] zero. A source is active when it is pending, its enable bit is 1 and its mask bit is 0. The read returns 0 when no source is active or when source 0 is the only active source.
- R3: `irq_o` is 1 exactly when at least one source is active. Enable banks are at 0x40, 0x44 and 0x48; mask banks are at 0x50, 0x54 and 0x58. All of these read back what was last written.
- R4: After reset, all enable, mask and pending bits are 0, the protection bit is 0, the trigger field is 00, `irq_o` is 0 and the vector reads 0.
- R5: Writing 1 to bit 0 of address 0x10 clears the source 0 pending bit. Writing 0 to that bit leaves it unchanged.
- R6: Once set, the source 0 pending bit stays 1 after the external pin returns to its idle level, until it is cleared by software.
- R7: Bits [1:0] of address 0x0C select the source 0 trigger: 00 low level, 01 high level, 10 falling edge, 11 rising edge. The trigger acts on a two-flop synchronised copy of the pin, so a pin change shows in pending bank 0 three clock edges later.
- R8: Bit 0 of address 0x08 is the protection bit. While it is 1, a write with `priv_i` low changes no register. A write with `priv_i` high is accepted.
- R9: The fast-interrupt pending addresses 0x20, 0x24 and 0x28, and every unmapped address, read as 0.
- R10: If the source 0 trigger fires in the same cycle as a software clear of that bit, the pending bit remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Source levels; bit 0 is the external pin with selectable trigger |
| priv_i | input | 1 | Privileged-access qualifier for writes |
| reg_addr_i | input | 8 | Register byte address |
| reg_we_i | input | 1 | Write enable, one write per cycle |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Two functions can meet in one cycle: the trigger that sets the source 0 pending bit, and a software write that clears it. The bench provokes this by selecting the high-level trigger, holding the pin high and writing one to bit 0 of pending bank 0. It judges the result by reading the pending bank on the next cycle, where the bit must still be 1. The same overlap also occurs many times in a random phase, where software clears land on trigger edges. There, a behavioural model that runs cycle by cycle settles which effect wins and compares the read data and `irq_o` on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int ADR_VEC  = 'h00;
  localparam int ADR_PROT = 'h08;
  localparam int ADR_XCTL = 'h0C;
  localparam int ADR_PEND = 'h10;
  localparam int ADR_FPND = 'h20;
  localparam int ADR_EN   = 'h40;
  localparam int ADR_MSK  = 'h50;

  typedef enum logic [1:0] {
    TRG_LOW  = 2'b00,
    TRG_HIGH = 2'b01,
    TRG_FALL = 2'b10,
    TRG_RISE = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/irqc_src0_capture.sv
module irqc_src0_capture
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  trig_mode_e mode_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic sync_a, sync_b, sync_prev;
  logic fire;

  // two-flop synchroniser plus one delayed copy for edge detection;
  // idle level is high so an active-low default does not fire at reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a    <= 1'b1;
      sync_b    <= 1'b1;
      sync_prev <= 1'b1;
    end else begin
      sync_a    <= pin_i;
      sync_b    <= sync_a;
      sync_prev <= sync_b;
    end
  end

  always_comb begin
    unique case (mode_i)
      TRG_LOW:  fire = !sync_b;
      TRG_HIGH: fire = sync_b;
      TRG_FALL: fire = sync_prev && !sync_b;
      TRG_RISE: fire = !sync_prev && sync_b;
      default:  fire = 1'b0;
    endcase
  end

  // set has priority over a coincident clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= fire || (pend_o && !clr_i);
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clr_i) |=> pend_o);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !fire) |=> !pend_o);
  p_setwins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && clr_i) |=> pend_o);
  p_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TRG_RISE && $rose(sync_b)) |=> pend_o);
endmodule

// File: rtl/irqc_lowest_pick.sv
module irqc_lowest_pick #(
  parameter int N    = 96,
  localparam int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    act_i,
  output logic [IDXW-1:0] idx_o,
  output logic            any_o
);
  // scan from the top so the lowest set index is assigned last
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) idx_o = IDXW'(i);
    end
  end

  assign any_o = |act_i;
endmodule

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
  import irqc_pkg::*;
#(
  parameter int NSRC = 96,
  localparam int NBANK = NSRC / REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   msk_o,
  output logic              prot_o,
  output trig_mode_e        mode_o,
  output logic              clr0_o
);
  logic wr_ok;
  assign wr_ok  = we_i && (!prot_o || priv_i);
  assign clr0_o = wr_ok && (addr_i == ADDR_W'(ADR_PEND)) && wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_o <= 1'b0;
      mode_o <= TRG_LOW;
    end else if (wr_ok) begin
      if (addr_i == ADDR_W'(ADR_PROT)) prot_o <= wdata_i[0];
      if (addr_i == ADDR_W'(ADR_XCTL)) mode_o <= trig_mode_e'(wdata_i[1:0]);
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [REG_W-1:0] en_r, msk_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_r  <= '0;
        msk_r <= '0;
      end else if (wr_ok) begin
        if (addr_i == ADDR_W'(ADR_EN + 4 * b))  en_r  <= wdata_i;
        if (addr_i == ADDR_W'(ADR_MSK + 4 * b)) msk_r <= wdata_i;
      end
    end
    assign en_o[b*REG_W +: REG_W]  = en_r;
    assign msk_o[b*REG_W +: REG_W] = msk_r;
  end

  p_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_o && we_i && !priv_i) |=>
      ($stable(en_o) && $stable(msk_o) && $stable(prot_o) && $stable(mode_o)));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC = 96,
  localparam int NBANK = NSRC / REG_W,
  localparam int IDXW  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [NSRC-1:0] en, msk, pend, active;
  logic [NSRC-1:1] lvl_q;
  logic            prot, clr0, pend0, any_act;
  trig_mode_e      mode;
  logic [IDXW-1:0] vec_idx;

  irqc_cfg_regs #(.NSRC(NSRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .priv_i(priv_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .en_o(en), .msk_o(msk), .prot_o(prot), .mode_o(mode), .clr0_o(clr0)
  );

  irqc_src0_capture u_src0 (
    .clk(clk), .rst_n(rst_n), .pin_i(src_i[0]), .mode_i(mode),
    .clr_i(clr0), .pend_o(pend0)
  );

  // level-following sources: pending is the sampled level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= src_i[NSRC-1:1];
  end

  assign pend   = {lvl_q, pend0};
  assign active = pend & en & ~msk;

  irqc_lowest_pick #(.N(NSRC)) u_pick (
    .act_i(active), .idx_o(vec_idx), .any_o(any_act)
  );

  assign irq_o = any_act;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADR_VEC))  reg_rdata_o = REG_W'({vec_idx, 2'b00});
    if (reg_addr_i == ADDR_W'(ADR_PROT)) reg_rdata_o = REG_W'(prot);
    if (reg_addr_i == ADDR_W'(ADR_XCTL)) reg_rdata_o = REG_W'(mode);
    for (int b = 0; b < NBANK; b++) begin
      if (reg_addr_i == ADDR_W'(ADR_PEND + 4 * b)) reg_rdata_o = pend[b*REG_W +: REG_W];
      if (reg_addr_i == ADDR_W'(ADR_FPND + 4 * b)) reg_rdata_o = '0;
      if (reg_addr_i == ADDR_W'(ADR_EN + 4 * b))   reg_rdata_o = en[b*REG_W +: REG_W];
      if (reg_addr_i == ADDR_W'(ADR_MSK + 4 * b))  reg_rdata_o = msk[b*REG_W +: REG_W];
    end
  end

  p_vec_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_idx != '0) |-> active[vec_idx]);
  p_vec_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_idx != '0) |-> !active[0]);
  p_irq_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_idx != '0) |-> irq_o);
  p_irq_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_idx == '0));
  p_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    src_i[NSRC-1] |=> pend[NSRC-1]);
endmodule

// File: tb/sim_banked_irq_ctrl.sv
module sim_banked_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src = '0;
  logic        priv = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  banked_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .priv_i(priv),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit [95:0] m_pend, m_en, m_msk;
  bit        m_prot;
  bit [1:0]  m_trig;
  bit        hist[$];

  always @(posedge clk) begin
    bit wok, s, p, set0, clr0;
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_msk = '0; m_prot = 0; m_trig = 0;
      hist = '{1'b1, 1'b1, 1'b1, 1'b1};
    end else begin
      wok = we && (!m_prot || priv);
      hist.push_front(src[0]);
      void'(hist.pop_back());
      s = hist[2];
      p = hist[3];
      case (m_trig)
        2'd0: set0 = !s;
        2'd1: set0 = s;
        2'd2: set0 = p && !s;
        default: set0 = !p && s;
      endcase
      clr0 = wok && addr == 8'h10 && wdata[0];
      for (int n = 1; n < NS; n++) m_pend[n] = src[n];
      m_pend[0] = set0 || (m_pend[0] && !clr0);
      if (wok) begin
        if (addr == 8'h08) m_prot = wdata[0];
        if (addr == 8'h0C) m_trig = wdata[1:0];
        for (int b = 0; b < 3; b++) begin
          if (addr == 8'(8'h40 + 4 * b)) m_en[b*32 +: 32] = wdata;
          if (addr == 8'(8'h50 + 4 * b)) m_msk[b*32 +: 32] = wdata;
        end
      end
    end
  end

  function automatic bit [31:0] m_read(bit [7:0] a);
    bit [95:0] act;
    bit [31:0] r;
    act = m_pend & m_en & ~m_msk;
    r = 0;
    if (a == 8'h00) begin
      for (int n = NS - 1; n >= 0; n--) if (act[n]) r = 32'(n) << 2;
    end
    if (a == 8'h08) r = {31'd0, m_prot};
    if (a == 8'h0C) r = {30'd0, m_trig};
    for (int b = 0; b < 3; b++) begin
      if (a == 8'(8'h10 + 4 * b)) r = m_pend[b*32 +: 32];
      if (a == 8'(8'h40 + 4 * b)) r = m_en[b*32 +: 32];
      if (a == 8'(8'h50 + 4 * b)) r = m_msk[b*32 +: 32];
    end
    return r;
  endfunction

  function automatic string tag_of(bit [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h08: return "R8";
      8'h0C: return "R7";
      8'h10: return "R6";
      8'h14, 8'h18: return "R1";
      8'h40, 8'h44, 8'h48, 8'h50, 8'h54, 8'h58: return "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 irq", {31'd0, irq}, {31'd0, |(m_pend & m_en & ~m_msk)});
      chk(tag_of(addr), rdata, m_read(addr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(bit [7:0] a, bit [31:0] d, bit pv);
    @(negedge clk); #1;
    addr = a; wdata = d; priv = pv; we = 1'b1;
    @(negedge clk); #1;
    we = 1'b0; priv = 1'b0;
  endtask

  task automatic rd_chk(string tag, bit [7:0] a, bit [31:0] exp);
    @(negedge clk); #1;
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    bit [7:0] alist [14] = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20,
                             8'h40, 8'h44, 8'h48, 8'h50, 8'h54, 8'h58, 8'h30};
    src[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;

    // R4: reset state
    rd_chk("R4 enable0", 8'h40, 32'h0);
    rd_chk("R4 vector", 8'h00, 32'h0);
    rd_chk("R4 trigger", 8'h0C, 32'h0);
    chk("R4 irq", {31'd0, irq}, 32'd0);

    // R2/R3/R1: level sources and priority
    wr(8'h40, 32'hFFFF_FFFF, 0);
    wr(8'h44, 32'hFFFF_FFFF, 0);
    wr(8'h48, 32'hFFFF_FFFF, 0);
    src[5] = 1; src[40] = 1; src[70] = 1;
    idle(2);
    rd_chk("R2 lowest wins", 8'h00, 32'd5 << 2);
    chk("R3 irq raised", {31'd0, irq}, 32'd1);
    wr(8'h50, 32'h0000_0020, 0);
    rd_chk("R2 masked skip", 8'h00, 32'd40 << 2);
    rd_chk("R1 bank1 level", 8'h14, 32'h0000_0100);
    wr(8'h14, 32'hFFFF_FFFF, 0);
    rd_chk("R1 clear no effect", 8'h14, 32'h0000_0100);
    rd_chk("R1 bank2 level", 8'h18, 32'h0000_0040);

    // R6/R5: rising-edge latch on source 0
    src[5] = 0; src[40] = 0; src[70] = 0;
    wr(8'h50, 32'h0, 0);
    wr(8'h0C, 32'h3, 0);
    src[0] = 0; idle(4);
    src[0] = 1; idle(4);
    src[0] = 0; idle(4);
    rd_chk("R6 latched after idle", 8'h10, 32'h1);
    rd_chk("R2 zero vector src0", 8'h00, 32'h0);
    chk("R3 irq from src0", {31'd0, irq}, 32'd1);
    wr(8'h10, 32'h0, 0);
    rd_chk("R5 write zero keeps", 8'h10, 32'h1);
    wr(8'h10, 32'h1, 0);
    rd_chk("R5 write one clears", 8'h10, 32'h0);

    // R7: falling edge
    wr(8'h0C, 32'h2, 0);
    src[0] = 1; idle(4);
    rd_chk("R7 no fire on rise", 8'h10, 32'h0);
    src[0] = 0; idle(4);
    src[0] = 1; idle(4);
    rd_chk("R7 falling latched", 8'h10, 32'h1);
    wr(8'h10, 32'h1, 0);

    // R10: high level held while clearing
    wr(8'h0C, 32'h1, 0);
    idle(2);
    wr(8'h10, 32'h1, 0);
    rd_chk("R10 set beats clear", 8'h10, 32'h1);
    // R7: low level
    wr(8'h0C, 32'h0, 0);
    wr(8'h10, 32'h1, 0);
    rd_chk("R7 low idle high", 8'h10, 32'h0);
    src[0] = 0; idle(4);
    rd_chk("R7 low level fires", 8'h10, 32'h1);
    src[0] = 1; idle(4);
    wr(8'h10, 32'h1, 0);

    // R8: protection
    wr(8'h08, 32'h1, 0);
    wr(8'h40, 32'h0, 0);
    rd_chk("R8 blocked write", 8'h40, 32'hFFFF_FFFF);
    wr(8'h40, 32'h0000_000F, 1);
    rd_chk("R8 privileged write", 8'h40, 32'h0000_000F);
    wr(8'h08, 32'h0, 1);
    rd_chk("R8 protection off", 8'h08, 32'h0);

    // R9: fast pending and holes
    rd_chk("R9 fast bank0", 8'h20, 32'h0);
    rd_chk("R9 fast bank2", 8'h28, 32'h0);
    rd_chk("R9 hole", 8'h30, 32'h0);

    // random phase checked by the model every clock
    for (int i = 0; i < 3000; i++) begin
      int r;
      @(negedge clk); #1;
      r = int'($urandom % 8);
      we = 1'b0;
      priv = 1'($urandom);
      if ($urandom % 4 == 0) src = {$urandom, $urandom, $urandom};
      addr = alist[$urandom % 14];
      wdata = $urandom;
      if (r < 3) we = 1'b1;
    end
    @(negedge clk); #1;
    we = 1'b0;
    idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule